// File: doc/BRIEF.md
# Memory Protection Region Checker

This block guards the memory bus of a small microcontroller. Software sets up a bank of address regions through a word-addressed register port. Each region has a power-of-two size and a base address, and its span is split into eight equal slices that can be switched off one at a time. Each region also carries a three-bit rights code and an execute-never flag. The bench also stores bufferable, cacheable, shareable and type-extension hints per region; the block reports these hints with a hit but does not act on them.

A master presents each access on the check port: the address, whether the master is privileged, whether the access is a write, whether it is an instruction fetch, and whether the processor is inside hard-fault or NMI handling. One clock later the block returns a permit or fault verdict, a hit flag, the number of the winning region and that region's hint bits. Software can switch the whole unit off. It can also keep the unit off while fault handlers run, and it can let privileged accesses that hit no region pass through.

Top module: `mpu_region_checker`

## Requirements
- R1: After reset the control word, the selected region number and every region's attribute word read as zero. The identity word (index 0) reads the region count in bits 15:8 and zero in bit 0, which means one unified map.
- R2: The register port uses word indexes: 1 = control, 2 = region select, 3 = base, 4 = attributes. Reads are combinational. The region select keeps its low bits (3 bits for 8 regions). The base reads back as stored bits 31:5, then bit 4 as 0, then the selected number in bits 3:0. The attribute word keeps bits 0, 5:1, 15:8, 21:16, 26:24 and 28; all other bits read as zero.
- R3: A base write with bit 4 set loads bits 3:0 into the region select in the same cycle. The base is then stored into that newly selected region.
- R4: When control bit 0 is clear, every access is permitted and reported with hit 0, region 0 and hint bits 0.
- R5: A region with size code N (attribute bits 5:1) covers 2^(N+1) bytes. Its start is the stored base with every bit below the region size ignored. Size codes below 4 act as 4, which gives 32 bytes.
- R6: Attribute bit 8+k set removes the k-th eighth of the region, counted from its start, so an access in that eighth does not hit the region.
- R7: When several enabled regions hit, the highest-numbered one decides the verdict. Its number appears on the region output and its attribute bits 21:16 appear on the hint output.
- R8: Rights code (attribute bits 26:24) gives these rights. 1: privileged read and write. 2: privileged read and write, user read only. 3: read and write for all. 5: privileged read only. 6: read only for all. 0, 4 and 7: no access for anyone.
- R9: An instruction fetch that hits a region with bit 28 set faults. Otherwise a fetch is checked as a read.
- R10: With the unit on, an access that hits no region faults. The exception is a privileged access while control bit 2 is set, which is permitted.
- R11: While the hard-fault/NMI input is high and control bit 1 is clear, the unit behaves as if switched off. With bit 1 set, the unit checks normally.
- R12: Each request cycle yields exactly one result cycle on the next clock. The result uses the configuration that held before any register write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel | input | 1 | Register port select |
| cfg_wr | input | 1 | Register write when selected |
| cfg_addr | input | 3 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| chk_valid | input | 1 | Access check request |
| chk_addr | input | 32 | Access address |
| chk_priv | input | 1 | Access is privileged |
| chk_write | input | 1 | Access is a write |
| chk_fetch | input | 1 | Access is an instruction fetch |
| chk_hfnmi | input | 1 | Processor is in hard-fault or NMI handling |
| res_valid | output | 1 | Verdict valid |
| res_permit | output | 1 | Access allowed |
| res_hit | output | 1 | Some region decided the verdict |
| res_region | output | 4 | Winning region number |
| res_attr | output | 6 | Hint bits of the winning region |

## Verification
The hardest case to reach is an address where overlapping regions and a removed slice meet. In that case the winner must fall back from the higher region to a lower one inside just one eighth of the span, and nowhere else. The stimulus builds a small region that is nested inside a larger one and removes one slice of the small region. It then probes the first and last word of that slice and the words just beyond it, once for read and once for write. A behavioural model in the bench works out the verdict on every clock from byte ranges and integer division. The model does not use masks. It also replays register writes that land while a request is held, so the same-cycle ordering gets exercised.

// File: rtl/mpu_region_checker.sv
module mpu_region_checker #(
  parameter int NUM_REGIONS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_sel,
  input  logic        cfg_wr,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        chk_valid,
  input  logic [31:0] chk_addr,
  input  logic        chk_priv,
  input  logic        chk_write,
  input  logic        chk_fetch,
  input  logic        chk_hfnmi,
  output logic        res_valid,
  output logic        res_permit,
  output logic        res_hit,
  output logic [3:0]  res_region,
  output logic [5:0]  res_attr
);

  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam logic [31:0] ATTR_KEEP = 32'h173F_FF3F;
  localparam logic [2:0] A_TYPE = 3'd0, A_CTRL = 3'd1, A_RNUM = 3'd2,
                         A_BASE = 3'd3, A_ATTR = 3'd4;

  logic [2:0]       ctrl_q;
  logic [IDX_W-1:0] rnr_q;
  logic [26:0]      base_q [NUM_REGIONS];
  logic [31:0]      attr_q [NUM_REGIONS];

  wire wr_en = cfg_sel & cfg_wr;
  wire [IDX_W-1:0] base_tgt = cfg_wdata[4] ? cfg_wdata[IDX_W-1:0] : rnr_q;
  wire rnr_ok = 32'(rnr_q) < NUM_REGIONS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rnr_q  <= '0;
    end else if (wr_en) begin
      if (cfg_addr == A_CTRL) ctrl_q <= cfg_wdata[2:0];
      if (cfg_addr == A_RNUM) rnr_q <= cfg_wdata[IDX_W-1:0];
      if (cfg_addr == A_BASE && cfg_wdata[4]) rnr_q <= cfg_wdata[IDX_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        attr_q[g] <= '0;
      end else if (wr_en) begin
        if (cfg_addr == A_BASE && base_tgt == IDX_W'(g)) base_q[g] <= cfg_wdata[31:5];
        if (cfg_addr == A_ATTR && rnr_q == IDX_W'(g)) attr_q[g] <= cfg_wdata & ATTR_KEEP;
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      A_TYPE: cfg_rdata = {16'd0, 8'(NUM_REGIONS), 8'd0};
      A_CTRL: cfg_rdata = {29'd0, ctrl_q};
      A_RNUM: cfg_rdata = 32'(rnr_q);
      A_BASE: if (rnr_ok) cfg_rdata = {base_q[rnr_q], 1'b0, 4'(rnr_q)};
      A_ATTR: if (rnr_ok) cfg_rdata = attr_q[rnr_q];
      default: cfg_rdata = '0;
    endcase
  end

  function automatic logic region_hit(input logic [31:0] a, input logic [26:0] base,
                                      input logic [31:0] attr);
    logic [4:0]  n;
    logic [31:0] span, keep, far;
    logic [7:0]  srd;
    n    = (attr[5:1] < 5'd4) ? 5'd4 : attr[5:1];
    span = 32'd1 << ({1'b0, n} + 6'd1);
    keep = ~(span - 32'd1);
    far  = a >> (n - 5'd2);
    srd  = attr[15:8];
    return attr[0] && (((a ^ {base, 5'b0}) & keep) == 32'd0) && !srd[far[2:0]];
  endfunction

  function automatic logic rights_ok(input logic [2:0] ap, input logic priv, input logic wr);
    case (ap)
      3'd1: return priv;
      3'd2: return priv | ~wr;
      3'd3: return 1'b1;
      3'd5: return priv & ~wr;
      3'd6: return ~wr;
      default: return 1'b0;
    endcase
  endfunction

  logic             hit;
  logic [IDX_W-1:0] win;

  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int i = 0; i < NUM_REGIONS; i++)
      if (region_hit(chk_addr, base_q[i], attr_q[i])) begin
        hit = 1'b1;
        win = IDX_W'(i);
      end
  end

  wire [31:0] win_attr = attr_q[win];
  wire eff   = ctrl_q[0] & (~chk_hfnmi | ctrl_q[1]);
  wire grant = !eff ? 1'b1 :
               hit  ? rights_ok(win_attr[26:24], chk_priv, chk_write & ~chk_fetch)
                      & ~(chk_fetch & win_attr[28]) :
                      chk_priv & ctrl_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_permit <= 1'b0;
      res_hit    <= 1'b0;
      res_region <= '0;
      res_attr   <= '0;
    end else begin
      res_valid  <= chk_valid;
      res_permit <= grant;
      res_hit    <= eff & hit;
      res_region <= (eff & hit) ? 4'(win) : 4'd0;
      res_attr   <= (eff & hit) ? win_attr[21:16] : 6'd0;
    end
  end

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> res_valid); // R12
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !res_valid); // R12
  AST_FAULT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_permit |-> $past(ctrl_q[0])); // R4
  AST_HANDLER_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && $past(chk_hfnmi && !ctrl_q[1]) |-> res_permit); // R11
  AST_MISS_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_permit && !res_hit |->
      $past(!ctrl_q[0] || (chk_hfnmi && !ctrl_q[1]) || (chk_priv && ctrl_q[2]))); // R10
  AST_BASE_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && cfg_addr == A_BASE && cfg_wdata[4] |=> rnr_q == $past(cfg_wdata[IDX_W-1:0])); // R3
  AST_REGION_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> 32'(res_region) < NUM_REGIONS); // R7

endmodule

// File: tb/test_mpu_region_checker.sv
module test_mpu_region_checker;
  localparam int NR = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_sel = 0, cfg_wr = 0;
  logic [2:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic chk_valid = 0, chk_priv = 0, chk_write = 0, chk_fetch = 0, chk_hfnmi = 0;
  logic [31:0] chk_addr = 0;
  logic res_valid, res_permit, res_hit;
  logic [3:0] res_region;
  logic [5:0] res_attr;

  mpu_region_checker #(.NUM_REGIONS(NR)) i_mpu_region_checker (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .chk_valid(chk_valid), .chk_addr(chk_addr),
    .chk_priv(chk_priv), .chk_write(chk_write), .chk_fetch(chk_fetch), .chk_hfnmi(chk_hfnmi),
    .res_valid(res_valid), .res_permit(res_permit), .res_hit(res_hit),
    .res_region(res_region), .res_attr(res_attr));

  int checks = 0, fails = 0;
  string tag = "R1";
  bit run = 0, done = 0;

  logic [31:0] m_base [NR];
  logic [31:0] m_attr [NR];
  logic [2:0]  m_ctrl;
  int          m_rnr;
  bit e_valid, e_permit, e_hit;
  int e_region;
  logic [5:0] e_attr;

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit m_match(int i, logic [31:0] a);
    int n;
    longint unsigned span, start, addr;
    int eighth;
    if (!m_attr[i][0]) return 0;
    n = int'(m_attr[i][5:1]);
    if (n < 4) n = 4;
    span  = 64'd1 << (n + 1);
    start = {32'd0, m_base[i]} & ~(span - 1);
    addr  = {32'd0, a};
    if (addr < start || addr >= start + span) return 0;
    eighth = int'((addr - start) / (span / 8));
    return !m_attr[i][8 + eighth];
  endfunction

  function automatic bit m_rights(int ap, bit priv, bit wr);
    bit pr, pw, ur, uw;
    {pr, pw, ur, uw} = 4'b0000;
    case (ap)
      1: {pr, pw} = 2'b11;
      2: {pr, pw, ur} = 3'b111;
      3: {pr, pw, ur, uw} = 4'b1111;
      5: pr = 1;
      6: {pr, ur} = 2'b11;
      default: ;
    endcase
    if (priv) return wr ? pw : pr;
    return wr ? uw : ur;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      e_valid = 0;
      m_ctrl = 0;
      m_rnr = 0;
      for (int i = 0; i < NR; i++) begin m_base[i] = 0; m_attr[i] = 0; end
    end else begin
      e_valid = chk_valid;
      e_hit = 0; e_region = 0; e_attr = 0; e_permit = 1;
      if (chk_valid && m_ctrl[0] && (!chk_hfnmi || m_ctrl[1])) begin
        int found;
        found = -1;
        for (int i = NR - 1; i >= 0; i--)
          if (found < 0 && m_match(i, chk_addr)) found = i;
        if (found >= 0) begin
          e_hit = 1; e_region = found; e_attr = m_attr[found][21:16];
          e_permit = m_rights(int'(m_attr[found][26:24]), chk_priv, chk_write && !chk_fetch)
                     && !(chk_fetch && m_attr[found][28]);
        end else e_permit = chk_priv && m_ctrl[2];
      end
      if (cfg_sel && cfg_wr)
        case (cfg_addr)
          3'd1: m_ctrl = cfg_wdata[2:0];
          3'd2: m_rnr = int'(cfg_wdata) & (NR - 1);
          3'd3: begin
            if (cfg_wdata[4]) m_rnr = int'(cfg_wdata[3:0]) & (NR - 1);
            m_base[m_rnr] = cfg_wdata & 32'hFFFF_FFE0;
          end
          3'd4: m_attr[m_rnr] = cfg_wdata & 32'h173F_FF3F;
          default: ;
        endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && run) begin
      chk("valid", res_valid, e_valid);
      if (e_valid) begin
        chk("permit", res_permit, e_permit);
        chk("hit", res_hit, e_hit);
        chk("region", res_region, e_region);
        chk("attr", res_attr, e_attr);
      end
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_sel = 1; cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_sel = 0; cfg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #2 chk("rdata", cfg_rdata, exp);
  endtask

  task automatic acc(logic [31:0] a, bit priv, bit w, bit f, bit h);
    @(negedge clk);
    chk_valid = 1; chk_addr = a; chk_priv = priv; chk_write = w; chk_fetch = f; chk_hfnmi = h;
  endtask

  task automatic idle();
    @(negedge clk);
    chk_valid = 0;
  endtask

  function automatic logic [31:0] mk(bit en, int n, logic [7:0] srd, int ap, bit xn, logic [5:0] hint);
    return {3'b0, xn, 1'b0, 3'(ap), 2'b0, hint, srd, 2'b0, 5'(n), en};
  endfunction

  task automatic finish();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog %s actual=hung expected=done", tag);
      finish();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    run = 1;
    tag = "R1";
    rd(3'd0, 32'h0000_0800);
    rd(3'd1, 32'h0);
    rd(3'd2, 32'h0);
    rd(3'd4, 32'h0);

    tag = "R4";
    acc(32'h0000_1234, 0, 1, 0, 0);
    acc(32'h2000_0000, 0, 0, 1, 0);
    idle();

    tag = "R2";
    wr(3'd2, 32'h0000_00FD);
    rd(3'd2, 32'h5);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, 32'h173F_FF3F);
    wr(3'd3, 32'hABCD_EFEF);
    rd(3'd3, 32'hABCD_EFE5);
    wr(3'd1, 32'hFFFF_FFF8);
    rd(3'd1, 32'h0);
    wr(3'd4, 32'h0);
    wr(3'd3, 32'h0);

    tag = "R3";
    wr(3'd3, 32'h2000_8012);
    rd(3'd2, 32'h2);
    rd(3'd3, 32'h2000_8002);
    wr(3'd4, mk(1, 12, 8'h02, 6, 1, 6'h00));
    wr(3'd3, 32'h2000_0011);
    wr(3'd4, mk(1, 15, 8'h00, 3, 0, 6'h0F));
    rd(3'd4, mk(1, 15, 8'h00, 3, 0, 6'h0F));
    wr(3'd3, 32'h0800_0133);
    wr(3'd4, mk(1, 9, 8'h00, 2, 0, 6'h22));
    wr(3'd3, 32'h4000_0054);
    wr(3'd4, mk(1, 2, 8'h00, 3, 0, 6'h01));

    tag = "R4";
    acc(32'h3000_0000, 0, 1, 0, 0);
    chk_valid = 1;
    wr(3'd1, 32'h1);

    tag = "R5";
    acc(32'h2000_1000, 0, 1, 0, 0);
    acc(32'h2000_FFFC, 0, 1, 0, 0);
    acc(32'h2001_0000, 0, 0, 0, 0);
    acc(32'h0800_03FC, 1, 1, 0, 0);
    acc(32'h0800_0000, 0, 0, 0, 0);
    acc(32'h0800_0400, 1, 0, 0, 0);
    acc(32'h4000_0044, 0, 1, 0, 0);
    acc(32'h4000_005C, 0, 0, 0, 0);
    acc(32'h4000_0060, 0, 0, 0, 0);
    acc(32'h4000_003C, 0, 0, 0, 0);

    tag = "R8";
    acc(32'h0800_0010, 0, 1, 0, 0);
    acc(32'h0800_0010, 0, 0, 0, 0);

    tag = "R7";
    acc(32'h2000_8000, 0, 0, 0, 0);
    acc(32'h2000_8000, 0, 1, 0, 0);
    acc(32'h2000_9FFC, 1, 1, 0, 0);

    tag = "R6";
    acc(32'h2000_8400, 0, 1, 0, 0);
    acc(32'h2000_87FC, 0, 1, 0, 0);
    acc(32'h2000_83FC, 0, 1, 0, 0);
    acc(32'h2000_8800, 0, 1, 0, 0);
    acc(32'h2000_8400, 0, 0, 1, 0);

    tag = "R9";
    acc(32'h2000_8000, 1, 0, 1, 0);
    acc(32'h2000_1000, 0, 1, 1, 0);
    acc(32'h0800_0020, 0, 0, 1, 0);

    tag = "R10";
    acc(32'h3000_0000, 1, 0, 0, 0);
    wr(3'd1, 32'h5);
    acc(32'h3000_0000, 1, 1, 0, 0);
    acc(32'h3000_0000, 0, 0, 0, 0);

    tag = "R11";
    wr(3'd1, 32'h1);
    acc(32'h3000_0000, 0, 1, 0, 1);
    acc(32'h2000_8000, 1, 0, 1, 1);
    wr(3'd1, 32'h3);
    acc(32'h3000_0000, 0, 1, 0, 1);
    acc(32'h2000_8000, 1, 0, 1, 1);

    tag = "R8";
    wr(3'd3, 32'h5000_0015);
    for (int ap = 0; ap < 8; ap++) begin
      wr(3'd4, mk(1, 4, 8'h00, ap, 0, 6'h00));
      for (int k = 0; k < 4; k++) acc(32'h5000_0008, k[1], k[0], 0, 0);
    end

    tag = "R7";
    wr(3'd3, 32'h0000_0010);
    wr(3'd4, mk(1, 31, 8'h00, 1, 0, 6'h3F));
    acc(32'h3000_0000, 0, 0, 0, 0);
    acc(32'hFFFF_FFFC, 1, 1, 0, 0);
    acc(32'h2000_1000, 0, 1, 0, 0);
    acc(32'h2000_8400, 0, 0, 0, 0);

    tag = "R12";
    idle();
    repeat (4) @(negedge clk);
    acc(32'h2000_1000, 0, 1, 0, 0);
    idle();
    repeat (3) @(negedge clk);

    done = 1;
    finish();
  end
endmodule